// File: doc/BRIEF.md
# Age-Ordered Clustered Issue Queue

This block holds up to twenty waiting integer operations and chooses, every cycle, which of them start execution on four sub-clusters: two upper ones (U0, U1) and two lower ones (L0, L1). Up to four operations enter per cycle through insert lanes. Each one carries an operation class, a mask of the sub-clusters it may use, two source tags with ready flags, and an opaque payload. The class narrows the mask: memory operations are kept to the lower pair, and shift operations to the upper pair. All other operations keep the mask they were given.

Result tags broadcast on the wakeup ports mark matching sources ready. An entry whose two sources are both ready asks for every sub-clusters its mask allows. An upper arbiter serves U0 and U1, and a lower arbiter serves L0 and L1. Each sub-cluster receives the oldest requester not already taken this cycle. Grants leave the block combinationally, and the granted entries are released at the next clock edge.

Top module: `clus_iq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the queue is empty: every gnt_valid_o bit is 0 and full_o is 0.
- R2: At one clock edge, each insert lane with its valid bit set is captured as one entry. Lane 0 is older than lane 1, lane 1 older than lane 2, and so on. Every entry inserted earlier is older than every entry inserted later. An entry whose sources are ready can be granted from the first cycle after its insertion edge.
- R3: full_o is 1 exactly when fewer than four of the twenty slots are occupied-free, that is, when more than sixteen entries are held. While full_o is 1, every insert lane is ignored.
- R4: At a clock edge, a valid wakeup tag equal to a source tag marks that source ready. This holds for held entries and for entries being inserted at the same edge. An entry requests only when both of its sources are ready.
- R5: Class encoding: 2'b01 is memory, with effective mask = mask & 4'b1100; 2'b10 is shift, with effective mask = mask & 4'b0011; 2'b00 and 2'b11 keep the mask. Mask bit and grant index order: 0 = U0, 1 = U1, 2 = L0, 3 = L1. No grant goes to a sub-cluster outside the effective mask.
- R6: Grants are chosen in the order U0, U1, L0, L1. Each one goes to the oldest requesting entry that is eligible for that sub-cluster and was not granted to an earlier sub-cluster in the same cycle.
- R7: Each sub-cluster receives at most one grant per cycle, and no entry is granted to two sub-clusters in one cycle. Up to four entries issue per cycle.
- R8: A granted entry leaves the queue at the next clock edge and is never granted again.
- R9: gnt_valid_o, gnt_slot_o and gnt_pay_o reflect the held entries in the same cycle, without a register stage. gnt_pay_o carries the payload that was inserted with the granted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | LANES | Insert lane valid |
| ins_cls_i | input | LANES x 2 | Operation class per lane |
| ins_mask_i | input | LANES x 4 | Sub-cluster mask per lane |
| ins_src_a_i | input | LANES x TAG_W | First source tag |
| ins_src_b_i | input | LANES x TAG_W | Second source tag |
| ins_rdy_a_i | input | LANES | First source already ready |
| ins_rdy_b_i | input | LANES | Second source already ready |
| ins_pay_i | input | LANES x PAY_W | Payload per lane |
| full_o | output | 1 | Insertion stalled |
| wk_valid_i | input | NWAKE | Wakeup broadcast valid |
| wk_tag_i | input | NWAKE x TAG_W | Wakeup destination tags |
| gnt_valid_o | output | 4 | Grant per sub-cluster |
| gnt_slot_o | output | 4 x IDX_W | Granted slot index |
| gnt_pay_o | output | 4 x PAY_W | Granted payload |

## Verification
A corrupted age relation appears at once at the grant ports, because a younger payload wins a sub-cluster in the same cycle as the conflict. A lost ready bit or a wrong steering mask shows as a payload that never issues, or that issues on the wrong half. A slot that is not freed shows one cycle after its grant, either as a second grant of the same payload or as full_o rising early. Each cycle, the bench compares full_o and all four grant payloads with a model that is ordered only by insertion sequence, so any of these faults is reported in the cycle where it first becomes visible.

// File: rtl/clus_iq_pkg.sv
`timescale 1ns/1ps
package clus_iq_pkg;
  localparam int NSUB = 4;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_MEM = 2'd1,
    CLS_SHF = 2'd2,
    CLS_ANY = 2'd3
  } op_cls_e;

  // memory ops stay low, shifts stay high
  function automatic logic [NSUB-1:0] steer(input logic [1:0] cls, input logic [NSUB-1:0] m);
    case (op_cls_e'(cls))
      CLS_MEM: return m & 4'b1100;
      CLS_SHF: return m & 4'b0011;
      default: return m;
    endcase
  endfunction
endpackage

// File: rtl/clus_iq_slot.sv
`timescale 1ns/1ps
module clus_iq_slot
  import clus_iq_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int PAY_W = 16,
  parameter int NWAKE = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alloc_i,
  input  logic [1:0]                  cls_i,
  input  logic [NSUB-1:0]             mask_i,
  input  logic [TAG_W-1:0]            src_a_i,
  input  logic [TAG_W-1:0]            src_b_i,
  input  logic                        rdy_a_i,
  input  logic                        rdy_b_i,
  input  logic [PAY_W-1:0]            pay_i,
  input  logic [NWAKE-1:0]            wk_valid_i,
  input  logic [NWAKE-1:0][TAG_W-1:0] wk_tag_i,
  input  logic                        free_i,
  output logic                        valid_o,
  output logic                        ready_o,
  output logic [NSUB-1:0]             mask_o,
  output logic [PAY_W-1:0]            pay_o
);
  logic             valid_q, rdy_a_q, rdy_b_q;
  logic [TAG_W-1:0] ta_q, tb_q;
  logic [NSUB-1:0]  mask_q;
  logic [PAY_W-1:0] pay_q;

  function automatic logic hit(input logic [TAG_W-1:0] t);
    logic h;
    h = 1'b0;
    for (int w = 0; w < NWAKE; w++)
      if (wk_valid_i[w] && wk_tag_i[w] == t) h = 1'b1;
    return h;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rdy_a_q <= 1'b0;
      rdy_b_q <= 1'b0;
      ta_q    <= '0;
      tb_q    <= '0;
      mask_q  <= '0;
      pay_q   <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      rdy_a_q <= rdy_a_i | hit(src_a_i);
      rdy_b_q <= rdy_b_i | hit(src_b_i);
      ta_q    <= src_a_i;
      tb_q    <= src_b_i;
      mask_q  <= steer(cls_i, mask_i);
      pay_q   <= pay_i;
    end else begin
      if (free_i) valid_q <= 1'b0;
      rdy_a_q <= rdy_a_q | hit(ta_q);
      rdy_b_q <= rdy_b_q | hit(tb_q);
    end
  end

  assign valid_o = valid_q;
  assign ready_o = rdy_a_q & rdy_b_q;
  assign mask_o  = mask_q;
  assign pay_o   = pay_q;
endmodule

// File: rtl/clus_iq_alloc.sv
`timescale 1ns/1ps
module clus_iq_alloc #(
  parameter int ENTRIES = 20,
  parameter int LANES   = 4,
  parameter int IDX_W   = 5,
  parameter int LANE_W  = 2
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [LANES-1:0]   ins_valid_i,
  output logic [ENTRIES-1:0] alloc_o,
  output logic [LANE_W-1:0]  lane_o [ENTRIES],
  output logic               full_o
);
  logic [IDX_W:0]  free_cnt;
  logic [LANE_W:0] cnt;
  logic            full;

  // lane n takes the n-th free slot counted from slot 0
  always_comb begin
    free_cnt = '0;
    for (int s = 0; s < ENTRIES; s++)
      if (!valid_i[s]) free_cnt = free_cnt + 1'b1;
    full = free_cnt < (IDX_W+1)'(LANES);
    alloc_o = '0;
    cnt = '0;
    for (int s = 0; s < ENTRIES; s++) begin
      lane_o[s] = '0;
      if (!valid_i[s] && cnt < (LANE_W+1)'(LANES)) begin
        lane_o[s] = cnt[LANE_W-1:0];
        alloc_o[s] = ins_valid_i[cnt[LANE_W-1:0]] & ~full;
        cnt = cnt + 1'b1;
      end
    end
  end

  assign full_o = full;
endmodule

// File: rtl/clus_iq_age.sv
`timescale 1ns/1ps
module clus_iq_age #(
  parameter int ENTRIES = 20,
  parameter int LANE_W  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ENTRIES-1:0]              alloc_i,
  input  logic [LANE_W-1:0]               lane_i [ENTRIES],
  output logic [ENTRIES-1:0][ENTRIES-1:0] older_o
);
  // older_q[i][j]: entry i is older than entry j
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        for (int j = 0; j < ENTRIES; j++)
          if (i != j) begin
            if (alloc_i[i] && alloc_i[j]) older_q[i][j] <= lane_i[i] < lane_i[j];
            else if (alloc_i[i])          older_q[i][j] <= 1'b0;
            else if (alloc_i[j])          older_q[i][j] <= 1'b1;
          end
    end
  end

  assign older_o = older_q;
endmodule

// File: rtl/clus_iq_pair.sv
`timescale 1ns/1ps
module clus_iq_pair #(
  parameter int ENTRIES = 20
) (
  input  logic [ENTRIES-1:0]              req_a_i,
  input  logic [ENTRIES-1:0]              req_b_i,
  input  logic [ENTRIES-1:0]              excl_i,
  input  logic [ENTRIES-1:0][ENTRIES-1:0] older_i,
  output logic [ENTRIES-1:0]              gnt_a_o,
  output logic [ENTRIES-1:0]              gnt_b_o
);
  function automatic logic [ENTRIES-1:0] pick(input logic [ENTRIES-1:0] req);
    logic [ENTRIES-1:0] win;
    for (int i = 0; i < ENTRIES; i++) begin
      win[i] = req[i];
      for (int j = 0; j < ENTRIES; j++)
        if (j != i && req[j] && older_i[j][i]) win[i] = 1'b0;
    end
    return win;
  endfunction

  always_comb begin
    gnt_a_o = pick(req_a_i & ~excl_i);
    gnt_b_o = pick(req_b_i & ~excl_i & ~gnt_a_o);
  end
endmodule

// File: rtl/clus_iq.sv
`timescale 1ns/1ps
module clus_iq
  import clus_iq_pkg::*;
#(
  parameter int ENTRIES = 20,
  parameter int LANES   = 4,
  parameter int NWAKE   = 4,
  parameter int TAG_W   = 6,
  parameter int PAY_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            ins_valid_i,
  input  logic [LANES-1:0][1:0]       ins_cls_i,
  input  logic [LANES-1:0][NSUB-1:0]  ins_mask_i,
  input  logic [LANES-1:0][TAG_W-1:0] ins_src_a_i,
  input  logic [LANES-1:0][TAG_W-1:0] ins_src_b_i,
  input  logic [LANES-1:0]            ins_rdy_a_i,
  input  logic [LANES-1:0]            ins_rdy_b_i,
  input  logic [LANES-1:0][PAY_W-1:0] ins_pay_i,
  output logic                        full_o,
  input  logic [NWAKE-1:0]            wk_valid_i,
  input  logic [NWAKE-1:0][TAG_W-1:0] wk_tag_i,
  output logic [NSUB-1:0]             gnt_valid_o,
  output logic [NSUB-1:0][IDX_W-1:0]  gnt_slot_o,
  output logic [NSUB-1:0][PAY_W-1:0]  gnt_pay_o
);
  logic [ENTRIES-1:0]              ent_valid, ent_ready, alloc, free;
  logic [NSUB-1:0]                 ent_mask [ENTRIES];
  logic [PAY_W-1:0]                ent_pay  [ENTRIES];
  logic [LANE_W-1:0]               alloc_lane [ENTRIES];
  logic [ENTRIES-1:0][ENTRIES-1:0] older;
  logic [NSUB-1:0][ENTRIES-1:0]    req, gnt;

  clus_iq_alloc #(.ENTRIES(ENTRIES), .LANES(LANES), .IDX_W(IDX_W), .LANE_W(LANE_W)) u_alloc (
    .valid_i(ent_valid), .ins_valid_i(ins_valid_i),
    .alloc_o(alloc), .lane_o(alloc_lane), .full_o(full_o)
  );

  clus_iq_age #(.ENTRIES(ENTRIES), .LANE_W(LANE_W)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_i(alloc), .lane_i(alloc_lane), .older_o(older)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    clus_iq_slot #(.TAG_W(TAG_W), .PAY_W(PAY_W), .NWAKE(NWAKE)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .alloc_i(alloc[g]),
      .cls_i(ins_cls_i[alloc_lane[g]]),
      .mask_i(ins_mask_i[alloc_lane[g]]),
      .src_a_i(ins_src_a_i[alloc_lane[g]]),
      .src_b_i(ins_src_b_i[alloc_lane[g]]),
      .rdy_a_i(ins_rdy_a_i[alloc_lane[g]]),
      .rdy_b_i(ins_rdy_b_i[alloc_lane[g]]),
      .pay_i(ins_pay_i[alloc_lane[g]]),
      .wk_valid_i(wk_valid_i), .wk_tag_i(wk_tag_i),
      .free_i(free[g]),
      .valid_o(ent_valid[g]), .ready_o(ent_ready[g]),
      .mask_o(ent_mask[g]), .pay_o(ent_pay[g])
    );
  end

  always_comb begin
    for (int k = 0; k < NSUB; k++)
      for (int s = 0; s < ENTRIES; s++)
        req[k][s] = ent_valid[s] & ent_ready[s] & ent_mask[s][k];
  end

  clus_iq_pair #(.ENTRIES(ENTRIES)) u_upper (
    .req_a_i(req[0]), .req_b_i(req[1]), .excl_i('0), .older_i(older),
    .gnt_a_o(gnt[0]), .gnt_b_o(gnt[1])
  );

  clus_iq_pair #(.ENTRIES(ENTRIES)) u_lower (
    .req_a_i(req[2]), .req_b_i(req[3]), .excl_i(gnt[0] | gnt[1]), .older_i(older),
    .gnt_a_o(gnt[2]), .gnt_b_o(gnt[3])
  );

  always_comb begin
    free = gnt[0] | gnt[1] | gnt[2] | gnt[3];
    for (int k = 0; k < NSUB; k++) begin
      gnt_valid_o[k] = |gnt[k];
      gnt_slot_o[k]  = '0;
      gnt_pay_o[k]   = '0;
      for (int s = 0; s < ENTRIES; s++)
        if (gnt[k][s]) begin
          gnt_slot_o[k] = IDX_W'(s);
          gnt_pay_o[k]  = ent_pay[s];
        end
    end
  end
endmodule

// File: rtl/clus_iq_chk.sv
`timescale 1ns/1ps
module clus_iq_chk #(
  parameter int ENTRIES = 20,
  parameter int IDX_W   = 5
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            full_i,
  input logic [3:0]                      gnt_valid_i,
  input logic [3:0][IDX_W-1:0]           gnt_slot_i,
  input logic [ENTRIES-1:0]              ent_valid_i,
  input logic [ENTRIES-1:0]              ent_ready_i,
  input logic [3:0]                      ent_mask_i [ENTRIES],
  input logic [ENTRIES-1:0][ENTRIES-1:0] older_i
);
  logic [3:0][ENTRIES-1:0] gm;
  logic [ENTRIES-1:0]      gall, prior;
  logic [3:0]              viol, stray;
  logic                    overlap;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      gm[k] = '0;
      if (gnt_valid_i[k] && gnt_slot_i[k] < IDX_W'(ENTRIES)) gm[k][gnt_slot_i[k]] = 1'b1;
    end
    gall = gm[0] | gm[1] | gm[2] | gm[3];
    overlap = 1'b0;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (|(gm[a] & gm[b])) overlap = 1'b1;
    prior = '0;
    for (int k = 0; k < 4; k++) begin
      viol[k]  = 1'b0;
      stray[k] = 1'b0;
      if (gnt_valid_i[k]) begin
        if (gnt_slot_i[k] >= IDX_W'(ENTRIES)) stray[k] = 1'b1;
        else begin
          if (!ent_valid_i[gnt_slot_i[k]] || !ent_ready_i[gnt_slot_i[k]] ||
              !ent_mask_i[gnt_slot_i[k]][k]) stray[k] = 1'b1;
          for (int j = 0; j < ENTRIES; j++)
            if (ent_valid_i[j] && ent_ready_i[j] && ent_mask_i[j][k] && !prior[j] &&
                older_i[j][gnt_slot_i[k]]) viol[k] = 1'b1;
        end
      end
      prior = prior | gm[k];
    end
  end

  p_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !(|gnt_valid_i)) |=> (ent_valid_i == $past(ent_valid_i)));

  // R4 and R5: a grant only goes to a held, ready entry eligible for that sub-cluster
  p_grant_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) stray == '0);

  p_oldest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) viol == '0);

  p_no_double_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) !overlap);

  p_freed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gall) |=> ((ent_valid_i & $past(gall)) == '0));
endmodule

bind clus_iq clus_iq_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_i(full_o),
  .gnt_valid_i(gnt_valid_o), .gnt_slot_i(gnt_slot_o),
  .ent_valid_i(ent_valid), .ent_ready_i(ent_ready),
  .ent_mask_i(ent_mask), .older_i(older)
);

// File: tb/clus_iq_test.sv
`timescale 1ns/1ps
module clus_iq_test;
  localparam int E = 20;
  localparam int L = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [L-1:0]       ins_valid;
  logic [L-1:0][1:0]  ins_cls;
  logic [L-1:0][3:0]  ins_mask;
  logic [L-1:0][5:0]  src_a, src_b;
  logic [L-1:0]       rdy_a, rdy_b;
  logic [L-1:0][15:0] pay;
  logic [3:0]         wk_valid;
  logic [3:0][5:0]    wk_tag;
  logic               full;
  logic [3:0]         gnt_valid;
  logic [3:0][4:0]    gnt_slot;
  logic [3:0][15:0]   gnt_pay;

  int total = 0, bad = 0, seq = 0;
  logic [15:0] next_pay = 16'h1;

  bit          m_v  [E];
  int          m_seq[E];
  logic [3:0]  m_mask[E];
  logic [5:0]  m_ta[E], m_tb[E];
  bit          m_ra[E], m_rb[E];
  logic [15:0] m_pay[E];

  always #2 clk_i = ~clk_i;

  clus_iq uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ins_valid_i(ins_valid), .ins_cls_i(ins_cls), .ins_mask_i(ins_mask),
    .ins_src_a_i(src_a), .ins_src_b_i(src_b), .ins_rdy_a_i(rdy_a), .ins_rdy_b_i(rdy_b),
    .ins_pay_i(pay), .full_o(full), .wk_valid_i(wk_valid), .wk_tag_i(wk_tag),
    .gnt_valid_o(gnt_valid), .gnt_slot_o(gnt_slot), .gnt_pay_o(gnt_pay)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] c, input logic [3:0] m);
    if (c == 2'd1) return m & 4'b1100;
    if (c == 2'd2) return m & 4'b0011;
    return m;
  endfunction

  function automatic bit woke(input logic [5:0] t);
    for (int w = 0; w < 4; w++) if (wk_valid[w] && wk_tag[w] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle();
    ins_valid = '0; ins_cls = '0; ins_mask = '0; src_a = '0; src_b = '0;
    rdy_a = '0; rdy_b = '0; pay = '0; wk_valid = '0; wk_tag = '0;
  endtask

  task automatic put(input int l, input logic [1:0] c, input logic [3:0] m,
                     input logic [5:0] ta, input bit ra, input logic [5:0] tb, input bit rb);
    ins_valid[l] = 1'b1; ins_cls[l] = c; ins_mask[l] = m;
    src_a[l] = ta; rdy_a[l] = ra; src_b[l] = tb; rdy_b[l] = rb;
    pay[l] = next_pay; next_pay = next_pay + 16'h1;
  endtask

  task automatic wake(input int w, input logic [5:0] t);
    wk_valid[w] = 1'b1; wk_tag[w] = t;
  endtask

  // inputs already driven after a falling edge; check, clock, update model
  task automatic step(input string req);
    int cnt; bit ef; int win[4]; bit taken[E];
    #1;
    cnt = 0;
    for (int e = 0; e < E; e++) begin taken[e] = 0; if (m_v[e]) cnt++; end
    ef = cnt > E - L;
    chk(full == ef, req, "full", 32'(full), 32'(ef));
    for (int k = 0; k < 4; k++) begin
      win[k] = -1;
      for (int e = 0; e < E; e++)
        if (m_v[e] && m_ra[e] && m_rb[e] && m_mask[e][k] && !taken[e] &&
            (win[k] < 0 || m_seq[e] < m_seq[win[k]])) win[k] = e;
      if (win[k] >= 0) taken[win[k]] = 1;
      chk(gnt_valid[k] == (win[k] >= 0), req, $sformatf("gnt_valid[%0d]", k),
          32'(gnt_valid[k]), 32'(win[k] >= 0));
      if (win[k] >= 0)
        chk(gnt_pay[k] == m_pay[win[k]], req, $sformatf("gnt_pay[%0d]", k),
            32'(gnt_pay[k]), 32'(m_pay[win[k]]));
    end
    @(posedge clk_i);
    for (int e = 0; e < E; e++) begin
      if (m_v[e]) begin m_ra[e] |= woke(m_ta[e]); m_rb[e] |= woke(m_tb[e]); end
      if (taken[e]) m_v[e] = 0;
    end
    if (!ef)
      for (int l = 0; l < L; l++)
        if (ins_valid[l])
          for (int e = 0; e < E; e++)
            if (!m_v[e]) begin
              m_v[e] = 1; m_seq[e] = seq++; m_mask[e] = exp_mask(ins_cls[l], ins_mask[l]);
              m_ta[e] = src_a[l]; m_tb[e] = src_b[l];
              m_ra[e] = rdy_a[l] | woke(src_a[l]); m_rb[e] = rdy_b[l] | woke(src_b[l]);
              m_pay[e] = pay[l];
              break;
            end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] m;
    void'($urandom(32'd20264));
    for (int e = 0; e < E; e++) m_v[e] = 0;
    idle();
    repeat (3) @(negedge clk_i);
    chk(gnt_valid == 4'b0, "R1", "gnt_valid in reset", 32'(gnt_valid), 0);
    chk(full == 1'b0, "R1", "full in reset", 32'(full), 0);
    rst_ni = 1'b1;
    step("R1");

    // R2: four lanes competing for U0 only, lane order decides
    for (int l = 0; l < L; l++) put(l, 2'd0, 4'b0001, 6'd0, 1, 6'd0, 1);
    step("R2");
    idle();
    repeat (5) step("R2");

    // R5: memory and shift ops with wide masks, plus a shift restricted to U0
    put(0, 2'd1, 4'b1111, 6'd0, 1, 6'd0, 1);
    put(1, 2'd2, 4'b1111, 6'd0, 1, 6'd0, 1);
    put(2, 2'd2, 4'b0101, 6'd0, 1, 6'd0, 1);
    put(3, 2'd1, 4'b1000, 6'd0, 1, 6'd0, 1);
    step("R5");
    idle();
    repeat (3) step("R5");

    // R4: same-edge wakeup on insert, then one source at a time
    put(0, 2'd0, 4'b1111, 6'd40, 0, 6'd0, 1);
    put(1, 2'd0, 4'b1111, 6'd41, 0, 6'd42, 0);
    wake(0, 6'd40);
    step("R4");
    idle(); step("R4");
    wake(1, 6'd41); step("R4");
    idle(); step("R4");
    wake(3, 6'd42); step("R4");
    idle(); repeat (2) step("R4");

    // R3: fill with waiting entries, insert while full is ignored
    for (int c = 0; c < 5; c++) begin
      for (int l = 0; l < L; l++) put(l, 2'd0, 4'b1111, 6'd63, 0, 6'd63, 0);
      step("R3");
      idle();
    end
    for (int l = 0; l < L; l++) put(l, 2'd0, 4'b1111, 6'd0, 1, 6'd0, 1);
    step("R3");
    idle(); step("R3");
    // R7: release everything, four issues per cycle
    wake(2, 6'd63); step("R7");
    idle(); repeat (6) step("R8");

    // R6: random traffic
    for (int c = 0; c < 3000; c++) begin
      idle();
      for (int l = 0; l < L; l++)
        if ($urandom_range(0, 2) != 0) begin
          ins_valid[l] = 1'b1;
          ins_cls[l] = 2'($urandom_range(0, 3));
          m = 4'($urandom_range(1, 15));
          if (exp_mask(ins_cls[l], m) == 4'b0) m = 4'b1111;
          ins_mask[l] = m;
          src_a[l] = 6'($urandom_range(0, 15)); rdy_a[l] = 1'($urandom_range(0, 1));
          src_b[l] = 6'($urandom_range(0, 15)); rdy_b[l] = 1'($urandom_range(0, 1));
          pay[l] = next_pay; next_pay = next_pay + 16'h1;
        end
      for (int w = 0; w < 4; w++)
        if ($urandom_range(0, 1) != 0) wake(w, 6'($urandom_range(0, 15)));
      step("R6");
    end
    idle();
    for (int t = 0; t < 16; t++) begin
      wake(t % 4, 6'(t)); 
      step("R9");
      idle();
    end
    repeat (8) step("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule